// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers event pulses from a four-link cell-transport device into one active-low interrupt pin. It uses two register levels. At the lower level, each link has a sticky status register with six event categories and an enable register of the same shape. The status register of link 0 also holds two group-wide event bits. At the upper level, a summary register has one bit per link. That bit is high while the link has any status bit that is both set and enabled. A master enable register chooses which link summaries can pull the pin low.

The summary level stores nothing. It is recomputed every cycle from the link registers. It falls as soon as software clears the pending link bits or drops their enables. Status bits go away only when software writes a 1 to them. Reads never clear anything, and accesses to the summary register change nothing.

Software uses a plain synchronous port: address, write strobe, write data and a combinational read-data output.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_n` is 1.
- R2: A one-cycle pulse on `link_evt[6*n+c]` sets bit c (0..5) of the status register of link n at the next clock edge. The bit stays set until it is cleared.
- R3: `grp_evt[g]` sets bit 6+g of the link 0 status register. On links 1 to 3, bits 6 and 7 of both status and enable read 0 and cannot be written.
- R4: Reading any register leaves every status bit unchanged.
- R5: Writing a 1 to a bit of a link status register clears that bit. Writing a 0 leaves the bit as it is. If an event pulse arrives in the same cycle as the clearing write, the bit stays set.
- R6: Summary register (address 0) bit n equals the OR of (status AND enable) of link n. It tracks changes in the same cycle, including an enable being written to 0.
- R7: `irq_n` is 0 exactly when some summary bit is 1 and its master enable bit (address 1, bits 3:0) is 1.
- R8: A write to address 0 changes no register and does not change `irq_n`.
- R9: Link n status is at address 2+2n and link n enable is at 3+2n. Addresses 10 to 15 read 0, and writes to them do nothing.
- R10: An enable register reads back the last value written to it, masked to its implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wr_data` |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| link_evt | input | 24 | Event pulses; bit 6n+c is category c of link n |
| grp_evt | input | 2 | Group-level event pulses, latched into link 0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A sticky bit that is wrongly set or lost shows up on `rd_data` for that link's status address one edge after the event or write. It reaches `irq_n` on the same edge once the link and master enables are set. The summary has no storage, so an error in it shows at the summary address and on the pin in the same cycle as the state that caused it. A stale summary bit left after an enable write is visible right after that write.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;

  function automatic int stat_off(int n);
    return 2 + 2 * n;
  endfunction

  function automatic int en_off(int n);
    return 3 + 2 * n;
  endfunction

  // mask of implemented bits for one link register
  function automatic logic [15:0] impl_mask(int cat, int grp, bit has_grp);
    logic [15:0] m;
    m = '0;
    for (int b = 0; b < 16; b++) begin
      if (b < cat) m[b] = 1'b1;
      else if (has_grp && b < cat + grp) m[b] = 1'b1;
    end
    return m;
  endfunction

  // sticky update: clear by write-one, set by event, set wins
  function automatic logic [15:0] sticky_next(logic [15:0] cur, logic [15:0] clr,
                                              logic [15:0] ev);
    return (cur & ~clr) | ev;
  endfunction

  function automatic logic link_pending(logic [15:0] st, logic [15:0] en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/irq_link_reg.sv
module irq_link_reg
  import irq_hier_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_CAT = 6,
  parameter int NUM_GRP = 2,
  parameter bit HAS_GRP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt,
  input  logic              stat_wr,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] en,
  output logic [DATA_W-1:0] clr,
  output logic              pend
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_mask(NUM_CAT, NUM_GRP, HAS_GRP));

  logic [DATA_W-1:0] stat_q, en_q, set_v, stat_d;

  assign set_v  = evt & IMPL;
  assign clr    = stat_wr ? (wdata & IMPL) : '0;
  assign stat_d = DATA_W'(sticky_next(16'(stat_q), 16'(clr), 16'(set_v)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_wr) en_q <= wdata & IMPL;
    end
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign pend = link_pending(16'(stat_q), 16'(en_q));
endmodule

// File: rtl/irq_master.sv
module irq_master #(
  parameter int NUM_LINKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] pend,
  input  logic                 men_wr,
  input  logic [NUM_LINKS-1:0] wdata,
  output logic [NUM_LINKS-1:0] mstat,
  output logic [NUM_LINKS-1:0] men,
  output logic                 irq_n
);
  logic [NUM_LINKS-1:0] men_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) men_q <= '0;
    else if (men_wr) men_q <= wdata;
  end

  assign mstat = pend;   // live summary, no storage
  assign men   = men_q;
  assign irq_n = ~|(pend & men_q);
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_hier_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [NUM_LINKS*DATA_W-1:0] stat_flat,
  input  logic [NUM_LINKS*DATA_W-1:0] en_flat,
  input  logic [NUM_LINKS-1:0]        mstat,
  input  logic [NUM_LINKS-1:0]        men,
  output logic                        men_wr,
  output logic [NUM_LINKS-1:0]        stat_wr,
  output logic [NUM_LINKS-1:0]        en_wr,
  output logic [DATA_W-1:0]           rd_data
);
  localparam logic [ADDR_W-1:0] A_MSTAT = '0;
  localparam logic [ADDR_W-1:0] A_MEN   = ADDR_W'(1);

  assign men_wr = wr_en && (addr == A_MEN);

  always_comb begin
    stat_wr = '0;
    en_wr   = '0;
    rd_data = '0;
    if (addr == A_MSTAT) rd_data = DATA_W'(mstat);
    if (addr == A_MEN)   rd_data = DATA_W'(men);
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (addr == ADDR_W'(stat_off(i))) begin
        stat_wr[i] = wr_en;
        rd_data    = stat_flat[i*DATA_W +: DATA_W];
      end
      if (addr == ADDR_W'(en_off(i))) begin
        en_wr[i] = wr_en;
        rd_data  = en_flat[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl #(
  parameter int NUM_LINKS = 4,
  parameter int NUM_CAT   = 6,
  parameter int NUM_GRP   = 2,
  parameter int ADDR_W    = 4,
  localparam int DATA_W   = NUM_CAT + NUM_GRP
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [NUM_LINKS*NUM_CAT-1:0] link_evt,
  input  logic [NUM_GRP-1:0]           grp_evt,
  output logic                         irq_n
);
  logic [NUM_LINKS*DATA_W-1:0] evt_flat, stat_flat, en_flat, clr_flat;
  logic [NUM_LINKS-1:0]        pend, stat_wr, en_wr, mstat, men;
  logic                        men_wr;

  irq_addr_dec #(.NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .stat_flat(stat_flat), .en_flat(en_flat),
    .mstat(mstat), .men(men), .men_wr(men_wr), .stat_wr(stat_wr),
    .en_wr(en_wr), .rd_data(rd_data)
  );

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    if (i == 0) begin : g_grp
      assign evt_flat[i*DATA_W +: DATA_W] = {grp_evt, link_evt[i*NUM_CAT +: NUM_CAT]};
    end else begin : g_plain
      assign evt_flat[i*DATA_W +: DATA_W] = {{NUM_GRP{1'b0}}, link_evt[i*NUM_CAT +: NUM_CAT]};
    end

    irq_link_reg #(
      .DATA_W(DATA_W), .NUM_CAT(NUM_CAT), .NUM_GRP(NUM_GRP), .HAS_GRP(i == 0)
    ) u_link (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_flat[i*DATA_W +: DATA_W]),
      .stat_wr(stat_wr[i]), .en_wr(en_wr[i]), .wdata(wr_data),
      .stat(stat_flat[i*DATA_W +: DATA_W]),
      .en(en_flat[i*DATA_W +: DATA_W]),
      .clr(clr_flat[i*DATA_W +: DATA_W]),
      .pend(pend[i])
    );
  end

  irq_master #(.NUM_LINKS(NUM_LINKS)) u_master (
    .clk(clk), .rst_n(rst_n), .pend(pend), .men_wr(men_wr),
    .wdata(wr_data[NUM_LINKS-1:0]), .mstat(mstat), .men(men), .irq_n(irq_n)
  );
endmodule

// File: rtl/irq_hier_chk.sv
module irq_hier_chk #(
  parameter int NUM_LINKS = 4,
  parameter int NUM_CAT   = 6,
  parameter int NUM_GRP   = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic                        irq_n,
  input logic [NUM_LINKS*DATA_W-1:0] evt_flat,
  input logic [NUM_LINKS*DATA_W-1:0] stat_flat,
  input logic [NUM_LINKS*DATA_W-1:0] en_flat,
  input logic [NUM_LINKS*DATA_W-1:0] clr_flat,
  input logic [NUM_LINKS-1:0]        mstat,
  input logic [NUM_LINKS-1:0]        men
);
  function automatic logic [NUM_LINKS*DATA_W-1:0] unimpl_mask();
    logic [NUM_LINKS*DATA_W-1:0] m;
    m = '0;
    for (int i = 1; i < NUM_LINKS; i++)
      for (int b = NUM_CAT; b < DATA_W; b++) m[i*DATA_W + b] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_LINKS-1:0] summary(logic [NUM_LINKS*DATA_W-1:0] s,
                                                   logic [NUM_LINKS*DATA_W-1:0] e);
    logic [NUM_LINKS-1:0] r;
    for (int i = 0; i < NUM_LINKS; i++)
      r[i] = (s[i*DATA_W +: DATA_W] & e[i*DATA_W +: DATA_W]) != '0;
    return r;
  endfunction

  localparam logic [NUM_LINKS*DATA_W-1:0] UNIMPL = unimpl_mask();

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flat & ~UNIMPL) != '0 |=>
      (stat_flat & $past(evt_flat & ~UNIMPL)) == $past(evt_flat & ~UNIMPL));

  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_flat & $past(stat_flat & ~clr_flat)) == $past(stat_flat & ~clr_flat));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flat != '0 |=> (stat_flat & $past(clr_flat & ~evt_flat)) == '0);

  assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_flat | en_flat) & UNIMPL) == '0);

  assert_summary_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mstat == summary(stat_flat, en_flat));

  assert_pin_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((mstat & men) == '0));

  assert_mstat_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> $stable(men) && $stable(en_flat));
endmodule

bind irq_hier_ctrl irq_hier_chk #(
  .NUM_LINKS(NUM_LINKS), .NUM_CAT(NUM_CAT), .NUM_GRP(NUM_GRP),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq_n(irq_n),
  .evt_flat(evt_flat), .stat_flat(stat_flat), .en_flat(en_flat),
  .clr_flat(clr_flat), .mstat(mstat), .men(men)
);

// File: tb/tb_irq_hier_ctrl.sv
`timescale 1ns/1ps
module tb_irq_hier_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [23:0] link_evt = '0;
  logic [1:0]  grp_evt = '0;
  logic        irq_n;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [7:0] m_stat [4];
  logic [7:0] m_en   [4];
  logic [3:0] m_men;

  irq_hier_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .link_evt(link_evt), .grp_evt(grp_evt), .irq_n(irq_n)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] lmask(int n);
    return (n == 0) ? 8'hFF : 8'h3F;
  endfunction

  function automatic logic [3:0] exp_summary();
    logic [3:0] s;
    for (int n = 0; n < 4; n++) begin
      s[n] = 1'b0;
      for (int b = 0; b < 8; b++) if (m_stat[n][b] && m_en[n][b]) s[n] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic exp_irq_n();
    return ((exp_summary() & m_men) == 4'h0);
  endfunction

  function automatic logic [7:0] exp_read(logic [3:0] a);
    if (a == 4'd0) return {4'h0, exp_summary()};
    if (a == 4'd1) return {4'h0, m_men};
    if (a >= 4'd2 && a <= 4'd9) begin
      if (a[0] == 1'b0) return m_stat[(int'(a) - 2) / 2];
      return m_en[(int'(a) - 3) / 2];
    end
    return 8'h00;
  endfunction

  function automatic string tag_for(logic [3:0] a);
    if (a == 4'd0) return "R6";
    if (a == 4'd1 || (a <= 4'd9 && a[0])) return "R10";
    if (a <= 4'd9) return "R2";
    return "R9";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(logic we, logic [3:0] a, logic [7:0] d,
                            logic [23:0] le, logic [1:0] ge);
    logic [7:0] ev;
    for (int n = 0; n < 4; n++) begin
      ev = {2'b00, le[n*6 +: 6]};
      if (n == 0) ev[7:6] = ge;
      for (int b = 0; b < 8; b++) begin
        if (lmask(n)[b]) begin
          if (ev[b]) m_stat[n][b] = 1'b1;
          else if (we && int'(a) == 2 + 2*n && d[b]) m_stat[n][b] = 1'b0;
        end
      end
      if (we && int'(a) == 3 + 2*n) m_en[n] = d & lmask(n);
    end
    if (we && a == 4'd1) m_men = d[3:0];
  endtask

  // drive at negedge, model at posedge, check 1ns after
  task automatic step(logic we, logic [3:0] a, logic [7:0] d,
                      logic [23:0] le, logic [1:0] ge, string tag);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d; link_evt = le; grp_evt = ge;
    @(posedge clk);
    model_edge(we, a, d, le, ge);
    #1;
    chk(tag, rd_data, exp_read(a));
    chk("R7", irq_n, exp_irq_n());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int n = 0; n < 4; n++) begin m_stat[n] = '0; m_en[n] = '0; end
    m_men = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state on every address
    for (int a = 0; a < 16; a++) begin
      step(1'b0, 4'(a), 8'h00, '0, '0, "R1");
      chk("R1", rd_data, 0);
      chk("R1", irq_n, 1);
    end

    // R2/R4/R6/R7: single link event path
    step(1'b1, 4'd7, 8'h08, '0, '0, "R10");          // link2 enable bit3
    step(1'b1, 4'd1, 8'h04, '0, '0, "R10");          // master enable link2
    step(1'b0, 4'd6, 8'h00, 24'h1 << 15, '0, "R2");  // link2 cat3 event
    chk("R2", rd_data, 8'h08);
    chk("R7", irq_n, 0);
    step(1'b0, 4'd6, 8'h00, '0, '0, "R4");           // reread keeps it
    chk("R4", rd_data, 8'h08);
    step(1'b0, 4'd0, 8'h00, '0, '0, "R6");
    chk("R6", rd_data, 8'h04);
    step(1'b1, 4'd1, 8'h00, '0, '0, "R7");
    chk("R7", irq_n, 1);
    step(1'b1, 4'd1, 8'h04, '0, '0, "R7");
    // R8: write to summary address
    step(1'b1, 4'd0, 8'hFF, '0, '0, "R8");
    chk("R8", rd_data, 8'h04);
    chk("R8", irq_n, 0);
    step(1'b0, 4'd1, 8'h00, '0, '0, "R8");
    chk("R8", rd_data, 8'h04);
    // R6: enable drop removes summary
    step(1'b1, 4'd7, 8'h00, '0, '0, "R10");
    step(1'b0, 4'd0, 8'h00, '0, '0, "R6");
    chk("R6", rd_data, 8'h00);
    chk("R6", irq_n, 1);
    step(1'b1, 4'd7, 8'h08, '0, '0, "R10");
    // R5: set wins, then clear
    step(1'b1, 4'd6, 8'h08, 24'h1 << 15, '0, "R5");
    chk("R5", rd_data, 8'h08);
    step(1'b1, 4'd6, 8'h00, '0, '0, "R5");
    chk("R5", rd_data, 8'h08);
    step(1'b1, 4'd6, 8'h08, '0, '0, "R5");
    chk("R5", rd_data, 8'h00);
    chk("R5", irq_n, 1);
    // R3: group bits only on link 0
    step(1'b0, 4'd2, 8'h00, '0, 2'b11, "R3");
    chk("R3", rd_data, 8'hC0);
    step(1'b1, 4'd5, 8'hFF, '0, '0, "R3");
    chk("R3", rd_data, 8'h3F);
    step(1'b1, 4'd4, 8'hFF, 24'hFC0, '0, "R3");
    chk("R3", rd_data, 8'h3F);
    step(1'b1, 4'd2, 8'hC0, '0, '0, "R3");
    chk("R3", rd_data, 8'h00);
    // R9: unmapped write ignored
    step(1'b1, 4'd12, 8'hFF, '0, '0, "R9");
    chk("R9", rd_data, 8'h00);

    // constrained random traffic
    for (int it = 0; it < 3000; it++) begin
      logic [23:0] le;
      logic [1:0]  ge;
      logic [3:0]  a;
      logic        we;
      le = '0;
      for (int b = 0; b < 24; b++) le[b] = ($urandom % 10) == 0;
      ge[0] = ($urandom % 12) == 0;
      ge[1] = ($urandom % 12) == 0;
      a  = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 10);
      we = ($urandom % 5) < 2;
      step(we, a, 8'($urandom), le, ge, tag_for(a));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule